// File: doc/BRIEF.md
# Edge-Triggered Interrupt Cause Unit

This block sits beside a serial controller and turns its level status flags into latched interrupt causes and one interrupt line. Each cause bit records a 0-to-1 transition of its status flag; a flag that simply stays high records nothing further. Software acknowledges a cause by writing 1 to it. A mask register selects which recorded causes drive the interrupt line.

Because causes latch on edges only, a flag that is already high when software enables it raises no interrupt. Software that waits on a flag must therefore read the flag itself before it waits. A rise that happens while its mask bit is off is still recorded, so enabling the mask later raises the line at once. A flag that is high while reset is asserted counts as already high, not as a rise.

A small word-addressed register port gives access to two registers: word 0 is the cause register (write 1 to clear) and word 1 is the mask register. Both are 32 bits wide. Status bits are assigned in this order:

| Bit | Flag |
|---|---|
| 0 | transfer done |
| 1 | transfer ready |
| 2 | receive FIFO ready |
| 3 | transmit FIFO ready |
| 4 | receive FIFO empty |
| 5 | receive FIFO full |
| 6 | transmit FIFO empty |
| 7 | transmit FIFO full |
| 8 | receive FIFO underflow |
| 9 | receive FIFO overflow |
| 10 | transmit FIFO underflow |
| 11 | transmit FIFO overflow |
| 12 | address not configured |

Top module: `irq_cause_unit`

## Requirements
- R1: A cause bit (bits 0 to 12, one per status bit, ordered as in the table above) becomes 1 on the clock edge where its status bit is sampled high after being sampled low on the previous edge.
- R2: A status bit that stays high does not set its cause bit again after the cause has been cleared.
- R3: Writing to word 0 clears every cause bit whose write-data bit is 1 and leaves the cause bits whose write-data bit is 0 unchanged.
- R4: After reset, the cause register and the mask register are all zeros and the interrupt output is low.
- R5: The interrupt output is high exactly when at least one cause bit and its mask bit are both 1. It is registered and follows the registers with one cycle of delay.
- R6: If a status rise and a write-1-to-clear hit the same cause bit in the same cycle, the bit ends up set.
- R7: A rise that occurs while its mask bit is 0 is still recorded in the cause register. Setting the mask bit later raises the interrupt.
- R8: Reads of words 0 and 1 return bits 31 to 13 as 0. Reads of words 2 and 3 return 0. Write-data bits 31 to 13 have no effect.
- R9: A status bit that is high while reset is asserted, and stays high afterwards, does not set its cause bit.
- R10: The read data is registered: it shows the addressed register, as it stood before the current edge, one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| status_i | input | 13 | Level status flags from the controller |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Word address: 0 cause, 1 mask |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt output |

## Verification
A status change or a register write applied before clock edge N updates the cause and mask registers at edge N. The read data and the interrupt line reflect that update at edge N+1. Every bench step therefore holds its stimulus for one edge, moves the address to the register it reads for the second edge, and samples both outputs at the falling edge after that second edge. A per-step arithmetic model of the previous status, the causes and the mask gives the expected values for directed cases on every bit and for a long pseudo-random sweep.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int unsigned NUM_SRC  = 13;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] ADDR_CAUSE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd1;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  // The previous sample tracks the input even in reset, so a flag that is
  // already high when reset ends does not count as a rise.
  always_ff @(posedge clk_i) begin
    prev_q <= level_i;
  end

  assign rise_o = rst_i ? '0 : (level_i & ~prev_q);

  p_rise_needs_low_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (rise_o != '0) |=> (($past(rise_o) & ~prev_q) == '0));
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int unsigned WIDTH = 13
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] rise_i,
  input  logic [WIDTH-1:0] clear_i,
  output logic [WIDTH-1:0] cause_o
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          bit_q <= 1'b0;
        end else if (rise_i[g]) begin
          bit_q <= 1'b1;
        end else if (clear_i[g]) begin
          bit_q <= 1'b0;
        end
      end
      assign cause_o[g] = bit_q;
    end
  endgenerate

  p_set_on_edge_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(rise_i)) == '0));
  p_w1c_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((cause_o & $past(clear_i) & ~$past(rise_i)) == '0));
  p_edge_wins_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (($past(rise_i) & ~cause_o) == '0));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_cause_pkg::*;
#(
  parameter int unsigned WIDTH = NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WIDTH-1:0]  cause_i,
  output logic [WIDTH-1:0]  clear_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - WIDTH;

  logic [WIDTH-1:0]  mask_q;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;
  logic [DATA_W-1:0] rd_mux;

  assign clear_o = (wr_en_i && addr_i == ADDR_CAUSE) ? wdata_i[WIDTH-1:0] : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mask_q <= '0;
    end else if (wr_en_i && addr_i == ADDR_MASK) begin
      mask_q <= wdata_i[WIDTH-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CAUSE: rd_mux = {{PAD_W{1'b0}}, cause_i};
      ADDR_MASK:  rd_mux = {{PAD_W{1'b0}}, mask_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_mux;
      irq_q   <= |(cause_i & mask_q);
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  p_mask_reset_r4: assert property (@(posedge clk_i)
    $fell(rst_i) |-> (mask_q == '0 && !irq_o));
  p_irq_steady_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    ($stable(cause_i) && $stable(mask_q)) |=> $stable(irq_o));
  p_upper_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    rdata_o[DATA_W-1:WIDTH] == '0);
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_cause_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] clear;
  logic [NUM_SRC-1:0] cause;

  irq_edge_detect #(.WIDTH(NUM_SRC)) u_edge (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .level_i (status_i),
    .rise_o  (rise)
  );

  irq_cause_bank #(.WIDTH(NUM_SRC)) u_bank (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .rise_i  (rise),
    .clear_i (clear),
    .cause_o (cause)
  );

  irq_reg_port #(.WIDTH(NUM_SRC)) u_port (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cause_i (cause),
    .clear_o (clear),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/irq_cause_unit_tb.sv
module irq_cause_unit_tb;
  localparam int NS = 13;

  logic        clk = 1'b0;
  logic        rst;
  logic [NS-1:0] status;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [NS-1:0] m_prev, m_cause, m_mask;

  always #2 clk = ~clk;

  irq_cause_unit u_dut (
    .clk_i(clk), .rst_i(rst), .status_i(status), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One step: stimulus held for one edge, then a read of raddr on the next
  // edge, sampled at the falling edge after that.
  task automatic step(input logic [NS-1:0] s, input logic we, input logic [1:0] wa,
                      input logic [31:0] wd, input logic [1:0] ra);
    logic [NS-1:0] clr;
    logic [31:0] exp_rd;
    status = s; wr_en = we; addr = wa; wdata = wd;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; addr = ra;
    @(posedge clk);
    @(negedge clk);
    clr = (we && wa == 2'd0) ? wd[NS-1:0] : '0;
    m_cause = (m_cause & ~clr) | (s & ~m_prev);
    if (we && wa == 2'd1) m_mask = wd[NS-1:0];
    m_prev = s;
    case (ra)
      2'd0: exp_rd = {19'd0, m_cause};
      2'd1: exp_rd = {19'd0, m_mask};
      default: exp_rd = 32'd0;
    endcase
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] ra);
    case (ra)
      2'd0: return {19'd0, m_cause};
      2'd1: return {19'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk_all(input string req, input logic [1:0] ra);
    check(req, rdata, exp_read(ra));
    check(req, {31'd0, irq}, {31'd0, |(m_cause & m_mask)});
  endtask

  initial begin
    logic [31:0] lfsr;
    rst = 1'b1; wr_en = 1'b0; addr = 2'd0; wdata = '0;
    status = 13'h0004;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_prev = 13'h0004; m_cause = '0; m_mask = '0;
    // R4: reset state
    check("R4 irq", {31'd0, irq}, 32'd0);
    step(13'h0004, 1'b0, 2'd1, 32'd0, 2'd1);
    check("R4 mask", rdata, 32'd0);
    step(13'h0004, 1'b0, 2'd0, 32'd0, 2'd0);
    // R9: flag high through reset does not latch
    check("R9 cause", rdata, 32'd0);
    step(13'h0000, 1'b0, 2'd0, 32'd0, 2'd0);

    // Per-bit sweep
    for (int i = 0; i < NS; i++) begin
      logic [NS-1:0] b;
      b = NS'(1) << i;
      step(b, 1'b0, 2'd0, 32'd0, 2'd0);
      check("R1 edge sets", rdata, {19'd0, b});
      check("R7 masked no irq", {31'd0, irq}, 32'd0);
      step(b, 1'b1, 2'd1, {19'h7FFFF, b}, 2'd1);
      check("R8 mask upper bits", rdata, {19'd0, b});
      check("R7 unmask irq", {31'd0, irq}, 32'd1);
      step(b, 1'b1, 2'd0, 32'hFFFFFFFF & ~{19'd0, b}, 2'd0);
      check("R3 zero keeps", rdata, {19'd0, b});
      step(b, 1'b1, 2'd0, {19'd0, b}, 2'd0);
      check("R3 one clears", rdata, 32'd0);
      check("R5 irq low", {31'd0, irq}, 32'd0);
      step(b, 1'b0, 2'd0, 32'd0, 2'd0);
      check("R2 steady high", rdata, 32'd0);
      step('0, 1'b0, 2'd0, 32'd0, 2'd0);
      step(b, 1'b1, 2'd0, {19'd0, b}, 2'd0);
      check("R6 edge beats clear", rdata, {19'd0, b});
      step('0, 1'b1, 2'd0, {19'd0, b}, 2'd2);
      check("R8 word2", rdata, 32'd0);
      step('0, 1'b1, 2'd1, 32'd0, 2'd3);
      check("R8 word3", rdata, 32'd0);
    end

    // R10: read data reflects register contents one clock after the address
    step(13'h0101, 1'b1, 2'd1, 32'h0000_0100, 2'd0);
    check("R10 read cause", rdata, 32'h0000_0101);
    check("R5 one enabled", {31'd0, irq}, 32'd1);

    // Pseudo-random sweep against the model
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 600; k++) begin
      logic [1:0] ra;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr[17:16];
      step(lfsr[NS-1:0] ^ lfsr[28:16], lfsr[20] & lfsr[21], {1'b0, lfsr[22]},
           {lfsr[7:0], lfsr[31:8]}, ra);
      chk_all("R1/R3/R5/R6 sweep", ra);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule